// File: doc/BRIEF.md
# Row-Sorted 3x3 Median Filter

This block takes nine 8-bit gray levels forming a 3x3 neighbourhood, all presented in one cycle with a valid strobe, and returns their median together with a valid strobe. It does not sort all nine values. Each row is ordered first by a three-input sorter. Three cross-row picks follow: the lowest of the row maxima, the middle of the row middles and the highest of the row minima. A last three-input sorter takes the middle of those three picks, and that value is the median of the window.

The work is split into three registered stages: row sort, cross-row pick and final pick. A new window can enter on every clock, and its result appears exactly three cycles later. Window assembly, line storage and border handling belong to the surrounding logic.

Top module: `median3x3_rowsort`

## Requirements
- R1: While `rst` is high, and on the first sampled edge after it falls, `out_valid` is 0.
- R2: `out_valid` equals `in_valid` delayed by exactly three clock cycles.
- R3: `out_median` equals the fifth-smallest of the nine inputs taken three cycles earlier. The inputs are packed in `in_win` with pixel index i occupying bits [8*i+7:8*i]. Row r holds pixels 3r, 3r+1 and 3r+2.
- R4: The filter takes one window per cycle. Back-to-back valid windows each give their own median, in order.
- R5: Results stay correct when values repeat, including nine equal pixels and windows made only of 0 and 255.
- R6: The result does not depend on how values are ordered within a row, or on which row holds which values.
- R7: `out_median` is always one of the nine input values of its window and lies within the range of those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Window strobe |
| in_win | input | 72 | Nine packed 8-bit pixels |
| out_valid | output | 1 | Result strobe |
| out_median | output | 8 | Median of the window |

## Verification
The bench targets windows where the median depends on duplicates. A sorter that breaks ties badly would return a value that is not in the window, or a neighbour of the true median. It also checks windows whose extremes sit at 0 and 255, where a wrong cross-row pick would let a saturated value through. Row permutations of the same nine values must give the same result; a cross-row stage that used the wrong row ranks would break this. Back-to-back windows with a gap in the strobe expose any stage that is skipped or doubled, because valid and data would then drift apart in time.

// File: rtl/median3x3_rowsort.sv
module median3x3_rowsort #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [9*PW-1:0] in_win,
  output logic          out_valid,
  output logic [PW-1:0] out_median
);
  localparam int LAT = 3;

  function automatic logic [3*PW-1:0] sort3(input logic [PW-1:0] a, b, c);
    logic [PW-1:0] lo, md, hi, t;
    lo = a; md = b; hi = c;
    if (lo > md) begin t = lo; lo = md; md = t; end
    if (md > hi) begin t = md; md = hi; hi = t; end
    if (lo > md) begin t = lo; lo = md; md = t; end
    return {hi, md, lo};
  endfunction

  logic [LAT-1:0] vld;
  logic [PW-1:0] rmin [3], rmid [3], rmax [3];
  logic [PW-1:0] min_of_max, mid_of_mid, max_of_min;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LAT-2:0], in_valid};
  end

  for (genvar r = 0; r < 3; r++) begin : g_row
    logic [3*PW-1:0] s;
    assign s = sort3(in_win[(3*r)*PW +: PW], in_win[(3*r+1)*PW +: PW],
                     in_win[(3*r+2)*PW +: PW]);
    always_ff @(posedge clk) begin
      rmin[r] <= s[0 +: PW];
      rmid[r] <= s[PW +: PW];
      rmax[r] <= s[2*PW +: PW];
    end
  end

  logic [3*PW-1:0] s_max, s_mid, s_min, s_fin;
  assign s_max = sort3(rmax[0], rmax[1], rmax[2]);
  assign s_mid = sort3(rmid[0], rmid[1], rmid[2]);
  assign s_min = sort3(rmin[0], rmin[1], rmin[2]);

  always_ff @(posedge clk) begin
    min_of_max <= s_max[0 +: PW];
    mid_of_mid <= s_mid[PW +: PW];
    max_of_min <= s_min[2*PW +: PW];
  end

  assign s_fin = sort3(min_of_max, mid_of_mid, max_of_min);

  always_ff @(posedge clk) out_median <= s_fin[PW +: PW];

  assign out_valid = vld[LAT-1];
endmodule

module median3x3_rowsort_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [9*PW-1:0] in_win,
  input logic          out_valid,
  input logic [PW-1:0] out_median
);
  logic [2:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (seen != 3'd7) seen <= seen + 3'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R1
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (seen == 3'd7) |-> (out_valid == $past(in_valid, 3))); // R2
  AST_MEDIAN_HIGH: assert property (@(posedge clk) disable iff (rst)
    (seen == 3'd7 && out_valid) |->
      ($countones({$past(in_win[0 +: PW],3) <= out_median, $past(in_win[PW +: PW],3) <= out_median,
        $past(in_win[2*PW +: PW],3) <= out_median, $past(in_win[3*PW +: PW],3) <= out_median,
        $past(in_win[4*PW +: PW],3) <= out_median, $past(in_win[5*PW +: PW],3) <= out_median,
        $past(in_win[6*PW +: PW],3) <= out_median, $past(in_win[7*PW +: PW],3) <= out_median,
        $past(in_win[8*PW +: PW],3) <= out_median}) >= 5)); // R3
  AST_MEDIAN_LOW: assert property (@(posedge clk) disable iff (rst)
    (seen == 3'd7 && out_valid) |->
      ($countones({$past(in_win[0 +: PW],3) >= out_median, $past(in_win[PW +: PW],3) >= out_median,
        $past(in_win[2*PW +: PW],3) >= out_median, $past(in_win[3*PW +: PW],3) >= out_median,
        $past(in_win[4*PW +: PW],3) >= out_median, $past(in_win[5*PW +: PW],3) >= out_median,
        $past(in_win[6*PW +: PW],3) >= out_median, $past(in_win[7*PW +: PW],3) >= out_median,
        $past(in_win[8*PW +: PW],3) >= out_median}) >= 5)); // R7
endmodule

bind median3x3_rowsort median3x3_rowsort_chk #(.PW(PW)) u_chk (.*);

// File: tb/sim_median3x3_rowsort.sv
module sim_median3x3_rowsort;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [71:0] in_win = '0;
  logic out_valid;
  logic [7:0] out_median;
  int n_run = 0, n_fail = 0;

  median3x3_rowsort u0 (.*);
  always #5 clk = ~clk;

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [7:0] ref_med(input logic [71:0] w);
    logic [7:0] a [9];
    logic [7:0] t;
    for (int i = 0; i < 9; i++) a[i] = w[8*i +: 8];
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 8 - i; j++)
        if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    return a[4];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic one(input string req, input logic [71:0] w);
    @(negedge clk); in_valid = 1; in_win = w;
    @(negedge clk); in_valid = 0; in_win = '0;
    @(negedge clk); check(req, out_valid, 0);
    @(negedge clk); check(req, out_valid, 1); check(req, out_median, ref_med(w));
    @(negedge clk); check(req, out_valid, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", out_valid, 0);
    rst = 0;
    @(negedge clk); check("R1", out_valid, 0);
  endtask

  task automatic t_basic();
    one("R3", {8'd9,8'd8,8'd7,8'd6,8'd5,8'd4,8'd3,8'd2,8'd1});
    one("R3", {8'd200,8'd13,8'd77,8'd4,8'd150,8'd99,8'd31,8'd250,8'd60});
    one("R2", {8'd1,8'd2,8'd3,8'd40,8'd50,8'd60,8'd7,8'd8,8'd9});
  endtask

  task automatic t_ties();
    one("R5", {9{8'd42}});
    one("R5", {8'd255,8'd0,8'd255,8'd0,8'd255,8'd0,8'd255,8'd0,8'd255});
    one("R5", {8'd0,8'd0,8'd0,8'd0,8'd255,8'd255,8'd255,8'd255,8'd0});
    one("R5", {8'd5,8'd5,8'd1,8'd5,8'd9,8'd9,8'd1,8'd1,8'd9});
  endtask

  task automatic t_perm();
    logic [71:0] a = {8'd90,8'd10,8'd50,8'd30,8'd70,8'd20,8'd80,8'd60,8'd40};
    logic [71:0] b = {a[23:0], a[71:24]};
    logic [71:0] c = {a[63:48],a[71:64],a[39:24],a[47:40],a[15:0],a[23:16]};
    one("R6", a); one("R6", b); one("R6", c);
    check("R6", ref_med(b), 50);
  endtask

  task automatic t_stream();
    logic [71:0] w [6];
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 9; i++) w[k][8*i +: 8] = 8'((k*37 + i*53 + i*i*11) % 256);
    fork
      begin
        for (int k = 0; k < 6; k++) begin
          @(negedge clk); in_valid = (k != 3); in_win = w[k];
        end
        @(negedge clk); in_valid = 0; in_win = '0;
      end
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          check("R4", out_valid, (k != 3));
          if (k != 3) check("R4", out_median, ref_med(w[k]));
        end
      end
    join
  endtask

  task automatic t_member();
    logic [71:0] w = {8'd3,8'd250,8'd17,8'd128,8'd64,8'd200,8'd1,8'd99,8'd180};
    logic hit = 0;
    one("R7", w);
    for (int i = 0; i < 9; i++) if (w[8*i +: 8] == 8'd99) hit = 1;
    check("R7", hit, 1);
    check("R7", ref_med(w), 99);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_ties();
    t_perm();
    t_stream();
    t_member();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule